// File: doc/BRIEF.md
# Cartridge Bank and Image-Select Decoder

This block sits behind the 8 KB cartridge ROM window of a home-computer cartridge and turns CPU writes into one of two things. After reset it is in bank mode: every write into the window loads a bank register from the write's address bits. The register is ANDed with a bank mask so that only banks present in the loaded image can be reached. Its value drives the upper address bits of the cartridge SRAM.

The window also carries a byte channel to a companion microcontroller that picks which image to load. To keep programs that bank-switch through unusual addresses from sending commands by accident, the channel stays hidden. It opens only after four exact data bytes are written, in order, to one fixed key offset. In select mode the CPU writes anything to the mark offset to announce a byte. It then writes anything to offset 0x10xy, where the low address byte xy is the payload, for example one character of a file name. That second write latches xy and raises a one-clock interrupt to the microcontroller. A write to the exit offset, or a reset, returns the block to bank mode.

The CPU bus is asynchronous to the block clock. The write strobe and the ROM select are synchronised, and a write is acted on once, on the falling edge of the synchronised write enable.

Top module: `cart_window_decoder`

## Requirements
- R1: After reset the bank output is 0, select mode is off, the interrupt and mark pulses are low and the latched byte is 0.
- R2: In bank mode, each write with the ROM select low loads bank with address bits [BANK_W:1] ANDed with bank_mask as it is at the time of the write (BANK_W=6 by default). A write with the ROM select high changes nothing.
- R3: In bank mode no write raises the interrupt or the mark pulse, including writes to offsets 0x1000 to 0x10FF.
- R4: Data bytes 0x55, 0xAA, 0xC3, 0x01 written in that order to offset 0x1002 enter select mode. Writes to other offsets in between do not disturb the progress. Each of these writes also loads the bank as in R2.
- R5: A wrong byte written to offset 0x1002 during the sequence returns progress to the start. A repeated 0x55 after a 0x55 is wrong and does not count as a new start.
- R6: In select mode, a write to offset 0x10xy raises mcu_irq for exactly one clock and latches xy on mcu_byte. mcu_byte holds its value until the next such write.
- R7: In select mode, a write to offset 0x0000 raises mcu_mark for exactly one clock. mcu_irq and mcu_mark are never high in the same cycle.
- R8: In select mode the bank output holds, and writes to any other offset have no effect.
- R9: In select mode, a write to offset 0x1FFE returns to bank mode without changing the bank. A reset at any point returns to bank mode and discards a partly entered key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_sel_n | input | 1 | Cartridge ROM window select, active low, asynchronous |
| we_n | input | 1 | CPU write enable, active low, asynchronous |
| addr | input | ADDR_W (13) | Byte offset of the access within the window |
| data | input | 8 | CPU write data |
| bank_mask | input | BANK_W (6) | Mask of the banks that exist in the loaded image |
| bank | output | BANK_W (6) | Registered bank number for the SRAM upper address bits |
| sel_mode | output | 1 | High while the image-select channel is open |
| mcu_irq | output | 1 | One-clock strobe: a payload byte has been latched |
| mcu_mark | output | 1 | One-clock strobe: start of a new payload byte |
| mcu_byte | output | 8 | Last latched payload byte |

## Verification
Two functions share a single write event. The last key byte both loads the bank and switches the mode, and the exit write both leaves select mode and has to leave the bank alone. Each is provoked by the vector table walking through the key and out again. Each is judged by reading the bank and the mode after the write: after the key byte the bank must hold the value decoded from that write's address, and the first channel write must then raise the interrupt. After the exit write the bank must still hold the value from before the exit, and the next window write must load a new bank. In every write the bench also counts cycles where the interrupt and the mark are high together, and that count must stay at zero.

// File: rtl/cart_win_pkg.sv
package cart_win_pkg;
  // Decoded meaning of a window offset
  typedef enum logic [2:0] {
    OFS_PLAIN,
    OFS_MARK,
    OFS_CHAN,
    OFS_KEY,
    OFS_EXIT
  } ofs_kind_t;
endpackage

// File: rtl/cart_wr_sync.sv
module cart_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic we_n,
  input  logic rom_sel_n,
  output logic wr_evt
);
  logic [STAGES:0]   we_sh;
  logic [STAGES-1:0] sel_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_sh  <= '1;
      sel_sh <= '1;
    end else begin
      we_sh  <= {we_sh[STAGES-1:0], we_n};
      sel_sh <= {sel_sh[STAGES-2:0], rom_sel_n};
    end
  end

  // falling edge of the synchronised strobe while the window is selected
  assign wr_evt = we_sh[STAGES] & ~we_sh[STAGES-1] & ~sel_sh[STAGES-1];
endmodule

// File: rtl/cart_unlock.sv
module cart_unlock #(
  parameter int              KEY_LEN = 4,
  parameter logic [8*KEY_LEN-1:0] KEY = 32'h55AAC301
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_evt,
  input  logic       at_key,
  input  logic       at_exit,
  input  logic [7:0] data,
  output logic       sel_mode
);
  localparam int CNT_W = $clog2(KEY_LEN + 1);
  localparam logic [CNT_W-1:0] OPEN = CNT_W'(KEY_LEN);

  logic [CNT_W-1:0] step;
  logic [7:0]       want;

  always_comb begin
    want = '0;
    for (int i = 0; i < KEY_LEN; i++)
      if (step == CNT_W'(i)) want = KEY[(KEY_LEN-1-i)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (wr_evt) begin
      if (step == OPEN) begin
        if (at_exit) step <= '0;
      end else if (at_key) begin
        if (data == want) step <= step + 1'b1;
        else              step <= '0;
      end
    end
  end

  assign sel_mode = (step == OPEN);
endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg #(
  parameter int BANK_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BANK_W-1:0] bank_bits,
  input  logic [BANK_W-1:0] bank_mask,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (rst)       bank <= '0;
    else if (load) bank <= bank_bits & bank_mask;
  end
endmodule

// File: rtl/cart_sel_chan.sv
module cart_sel_chan (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_wr,
  input  logic       mark_wr,
  input  logic [7:0] payload,
  output logic       mcu_irq,
  output logic       mcu_mark,
  output logic [7:0] mcu_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mcu_irq  <= 1'b0;
      mcu_mark <= 1'b0;
      mcu_byte <= '0;
    end else begin
      mcu_irq  <= byte_wr;
      mcu_mark <= mark_wr;
      if (byte_wr) mcu_byte <= payload;
    end
  end
endmodule

// File: rtl/cart_window_decoder.sv
module cart_window_decoder
  import cart_win_pkg::*;
#(
  parameter int                BANK_W    = 6,
  parameter int                ADDR_W    = 13,
  parameter int                SYNC_W    = 2,
  parameter int                KEY_LEN   = 4,
  parameter logic [8*KEY_LEN-1:0] KEY    = 32'h55AAC301,
  parameter logic [ADDR_W-1:0] KEY_OFS   = 13'h1002,
  parameter logic [ADDR_W-1:0] EXIT_OFS  = 13'h1FFE,
  parameter logic [ADDR_W-1:0] MARK_OFS  = 13'h0000,
  parameter logic [ADDR_W-9:0] CHAN_PAGE = 5'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rom_sel_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic [BANK_W-1:0] bank_mask,
  output logic [BANK_W-1:0] bank,
  output logic              sel_mode,
  output logic              mcu_irq,
  output logic              mcu_mark,
  output logic [7:0]        mcu_byte
);
  logic      wr_evt;
  ofs_kind_t kind;

  always_comb begin
    if      (addr == KEY_OFS)                kind = OFS_KEY;
    else if (addr == EXIT_OFS)               kind = OFS_EXIT;
    else if (addr == MARK_OFS)               kind = OFS_MARK;
    else if (addr[ADDR_W-1:8] == CHAN_PAGE)  kind = OFS_CHAN;
    else                                     kind = OFS_PLAIN;
  end

  cart_wr_sync #(.STAGES(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .we_n(we_n), .rom_sel_n(rom_sel_n), .wr_evt(wr_evt)
  );

  cart_unlock #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_unlock (
    .clk(clk), .rst(rst), .wr_evt(wr_evt),
    .at_key(kind == OFS_KEY), .at_exit(kind == OFS_EXIT),
    .data(data), .sel_mode(sel_mode)
  );

  cart_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst(rst), .load(wr_evt & ~sel_mode),
    .bank_bits(addr[BANK_W:1]), .bank_mask(bank_mask), .bank(bank)
  );

  cart_sel_chan u_chan (
    .clk(clk), .rst(rst),
    .byte_wr(wr_evt & sel_mode & (kind == OFS_CHAN)),
    .mark_wr(wr_evt & sel_mode & (kind == OFS_MARK)),
    .payload(addr[7:0]),
    .mcu_irq(mcu_irq), .mcu_mark(mcu_mark), .mcu_byte(mcu_byte)
  );
endmodule

// File: rtl/cart_window_chk.sv
module cart_window_chk #(
  parameter int BANK_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [BANK_W-1:0] bank,
  input logic              sel_mode,
  input logic              mcu_irq,
  input logic              mcu_mark,
  input logic [7:0]        mcu_byte
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (bank == '0 && !sel_mode && !mcu_irq && !mcu_mark && mcu_byte == 8'h00));

  assert_irq_needs_sel_R3: assert property (@(posedge clk) disable iff (rst)
    mcu_irq |-> $past(sel_mode));

  assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    mcu_irq |=> !mcu_irq);

  assert_byte_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !mcu_irq |-> $stable(mcu_byte));

  assert_mark_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    mcu_mark |=> !mcu_mark);

  assert_no_irq_with_mark_R7: assert property (@(posedge clk) disable iff (rst)
    !(mcu_irq && mcu_mark));

  assert_bank_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (sel_mode && $past(sel_mode)) |-> $stable(bank));
endmodule

bind cart_window_decoder cart_window_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .bank(bank), .sel_mode(sel_mode),
  .mcu_irq(mcu_irq), .mcu_mark(mcu_mark), .mcu_byte(mcu_byte)
);

// File: tb/sim_cart_window_decoder.sv
module sim_cart_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rom_sel_n = 1'b1;
  logic        we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  data = '0;
  logic [5:0]  bank_mask = 6'h0F;
  logic [5:0]  bank;
  logic        sel_mode, mcu_irq, mcu_mark;
  logic [7:0]  mcu_byte;

  int checks = 0;
  int fails  = 0;
  int n_irq, n_mark, n_both;
  bit done = 0;

  always #4 clk = ~clk;

  cart_window_decoder u0 (
    .clk(clk), .rst(rst), .rom_sel_n(rom_sel_n), .we_n(we_n), .addr(addr),
    .data(data), .bank_mask(bank_mask), .bank(bank), .sel_mode(sel_mode),
    .mcu_irq(mcu_irq), .mcu_mark(mcu_mark), .mcu_byte(mcu_byte)
  );

  // row: addr, data, exp bank, exp sel, exp irq count, exp mark count, exp byte
  localparam int NV = 14;
  localparam logic [37:0] VEC [NV] = '{
    {13'h0006, 8'h00, 6'h03, 1'b0, 1'b0, 1'b0, 8'h00},
    {13'h0050, 8'h00, 6'h08, 1'b0, 1'b0, 1'b0, 8'h00},
    {13'h1034, 8'h5A, 6'h0A, 1'b0, 1'b0, 1'b0, 8'h00},
    {13'h1002, 8'h55, 6'h01, 1'b0, 1'b0, 1'b0, 8'h00},
    {13'h1002, 8'hAA, 6'h01, 1'b0, 1'b0, 1'b0, 8'h00},
    {13'h1002, 8'hC3, 6'h01, 1'b0, 1'b0, 1'b0, 8'h00},
    {13'h1002, 8'h01, 6'h01, 1'b1, 1'b0, 1'b0, 8'h00},
    {13'h0000, 8'h00, 6'h01, 1'b1, 1'b0, 1'b1, 8'h00},
    {13'h1041, 8'h77, 6'h01, 1'b1, 1'b1, 1'b0, 8'h41},
    {13'h0000, 8'h00, 6'h01, 1'b1, 1'b0, 1'b1, 8'h41},
    {13'h1054, 8'h00, 6'h01, 1'b1, 1'b1, 1'b0, 8'h54},
    {13'h0040, 8'h00, 6'h01, 1'b1, 1'b0, 1'b0, 8'h54},
    {13'h1FFE, 8'h00, 6'h01, 1'b0, 1'b0, 1'b0, 8'h54},
    {13'h0006, 8'h00, 6'h03, 1'b0, 1'b0, 1'b0, 8'h54}
  };

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [7:0] d, input logic cs_n);
    n_irq = 0; n_mark = 0; n_both = 0;
    addr = a; data = d; rom_sel_n = cs_n; we_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 4) begin we_n = 1'b1; rom_sel_n = 1'b1; end
      n_irq  += int'(mcu_irq);
      n_mark += int'(mcu_mark);
      n_both += int'(mcu_irq & mcu_mark);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_key(input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] b3);
    bus_write(13'h1002, b0, 1'b0);
    bus_write(13'h1002, b1, 1'b0);
    bus_write(13'h1002, b2, 1'b0);
    bus_write(13'h1002, b3, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(bank, 0, "R1 bank");
    check(sel_mode, 0, "R1 sel_mode");
    check(mcu_irq, 0, "R1 irq");
    check(mcu_mark, 0, "R1 mark");
    check(mcu_byte, 0, "R1 byte");

    for (int v = 0; v < NV; v++) begin
      bus_write(VEC[v][37:25], VEC[v][24:17], 1'b0);
      check(bank, int'(VEC[v][16:11]), "R2 bank per vector");
      check(sel_mode, int'(VEC[v][10]), "R4 mode per vector");
      check(n_irq, int'(VEC[v][9]), VEC[v][10] ? "R6 irq pulse count" : "R3 no irq in bank mode");
      check(n_mark, int'(VEC[v][8]), VEC[v][10] ? "R7 mark pulse count" : "R3 no mark in bank mode");
      check(n_both, 0, "R7 irq and mark together");
      check(mcu_byte, int'(VEC[v][7:0]), "R6 latched byte");
    end

    // R5: repeated 0x55 is wrong, sequence must not open
    bus_write(13'h1002, 8'h55, 1'b0);
    send_key(8'h55, 8'hAA, 8'hC3, 8'h01);
    check(sel_mode, 0, "R5 wrong byte restarts");
    // R5: wrong magic byte mid-way
    send_key(8'h55, 8'hAA, 8'hC4, 8'h01);
    check(sel_mode, 0, "R5 wrong magic");

    // R4: unrelated write between key bytes does not disturb progress
    bus_write(13'h1002, 8'h55, 1'b0);
    bus_write(13'h1002, 8'hAA, 1'b0);
    bus_write(13'h1002, 8'hC3, 1'b0);
    bus_write(13'h0010, 8'h00, 1'b0);
    check(bank, 8, "R4 interleaved write loads bank");
    bus_write(13'h1002, 8'h01, 1'b0);
    check(sel_mode, 1, "R4 opens after interleave");
    check(bank, 1, "R4 key write loads bank");

    // R8: plain writes in select mode leave bank alone
    bus_write(13'h007E, 8'h00, 1'b0);
    check(bank, 1, "R8 bank frozen");
    check(n_irq + n_mark, 0, "R8 plain write no pulse");

    // R9: reset leaves select mode
    do_reset();
    check(sel_mode, 0, "R9 reset exits select");
    check(bank, 0, "R1 bank after reset");
    check(mcu_byte, 0, "R1 byte after reset");

    // R9: partial key discarded by reset
    bus_write(13'h1002, 8'h55, 1'b0);
    bus_write(13'h1002, 8'hAA, 1'b0);
    bus_write(13'h1002, 8'hC3, 1'b0);
    do_reset();
    bus_write(13'h1002, 8'h01, 1'b0);
    check(sel_mode, 0, "R9 partial key cleared");

    // R2: ROM select high ignored, full mask
    bus_write(13'h0006, 8'h00, 1'b1);
    check(bank, 1, "R2 deselected write ignored");
    bank_mask = 6'h3F;
    bus_write(13'h007E, 8'h00, 1'b0);
    check(bank, 6'h3F, "R2 full mask");
    bank_mask = 6'h05;
    bus_write(13'h007E, 8'h00, 1'b0);
    check(bank, 6'h05, "R2 sparse mask");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule